// File: doc/BRIEF.md
# Far-End Receive Failure Status Extractor

This block turns the two far-end status bits that a DS3 receiver pulls out of every M-frame into a single far-end receive failure indication. At the end of each M-frame the framer presents both status bits together with a one-cycle frame-end strobe and its current out-of-frame state. A pair of zeros means that the far end reports a failure. A pair of ones means that it reports none. A mismatched pair is treated as corrupted and leaves the decoded state unchanged.

The decoded value does not reach the output directly. It passes through a two-stage history. The newer stage holds the status of the most recent frame and the older stage holds the status of the frame before it. The output is taken from the older stage. If alignment is lost, a frame-end strobe arriving with out-of-frame asserted leaves the older stage, and so the reported value, frozen. The newer stage keeps decoding on every strobe. The first strobe after alignment returns moves the newer stage's value to the output, and normal shifting resumes from there. The output can drive a pin directly or be read as a status bit.

Top module: `ferf_extract`

## Requirements
- R1: While reset is applied, and after it is released until the first frame-end strobe, `ferf_status` is 0.
- R2: A strobe with `xbit_a`=0 and `xbit_b`=0 decodes the frame as failure (1).
- R3: A strobe with `xbit_a`=1 and `xbit_b`=1 decodes the frame as no failure (0).
- R4: A strobe with `xbit_a` not equal to `xbit_b` keeps the decoded value of the previous frame.
- R5: Without a strobe, `ferf_status` and the decoded state do not change, whatever the status bits and `oof` do.
- R6: When `oof` is 0, the value decoded at strobe k appears on `ferf_status` in the cycle after strobe k+1, and not after strobe k.
- R7: A strobe that arrives with `oof`=1 leaves `ferf_status` unchanged.
- R8: Strobes that arrive with `oof`=1 still update the decoded state. The first strobe with `oof`=0 afterwards reports the value decoded at the last strobe taken during out-of-frame.
- R9: Once `oof` returns to 0, each later strobe moves the decoded state to the output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mframe_end | input | 1 | One-cycle strobe at the end of each M-frame |
| xbit_a | input | 1 | First extracted status bit of the frame |
| xbit_b | input | 1 | Second extracted status bit of the frame |
| oof | input | 1 | Out-of-frame state, sampled on the strobe |
| ferf_status | output | 1 | Reported far-end receive failure, 1 = failure |

## Verification
The hardest case to reach is the one where the newer stage moves away from the frozen output while out-of-frame is asserted. This shows up only on the first strobe after alignment returns. The stimulus first settles the output at one value and then raises out-of-frame. During out-of-frame it sends frames that decode to the opposite value, including a mismatched pair that must hold that opposite value. It checks that the output does not move during that time, and then drops out-of-frame and sends one more strobe. After that strobe the output has to show the value decoded while out-of-frame, and not the frame sent with the clearing strobe.

// File: rtl/ferf_pkg.sv
package ferf_pkg;
  localparam int unsigned RST_SYNC_STAGES = 2;

  typedef struct packed {
    logic bit_a;
    logic bit_b;
  } xpair_t;

  localparam logic FERF_FAIL = 1'b1;
  localparam logic FERF_OK   = 1'b0;
endpackage

// File: rtl/ferf_rst_sync.sv
module ferf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ferf_xbit_decode.sv
module ferf_xbit_decode
  import ferf_pkg::*;
(
  input  xpair_t pair,
  input  logic   prev_state,
  output logic   next_state
);
  always_comb begin
    if (pair.bit_a == pair.bit_b) next_state = pair.bit_a ? FERF_OK : FERF_FAIL;
    else                          next_state = prev_state;
  end
endmodule

// File: rtl/ferf_history.sv
module ferf_history (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic hold_older,
  input  logic newest_val,
  output logic newer_q,
  output logic older_q
);
  logic newer_d;
  logic older_d;
  logic newer_en;
  logic older_en;

  always_comb begin
    newer_en = frame_tick;
    older_en = frame_tick && !hold_older;
    newer_d  = newer_en ? newest_val : newer_q;
    older_d  = older_en ? newer_q    : older_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      newer_q <= 1'b0;
      older_q <= 1'b0;
    end else begin
      newer_q <= newer_d;
      older_q <= older_d;
    end
  end

  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(older_q) && $stable(newer_q))); // R5
  AST_FROZEN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && hold_older) |=> $stable(older_q)); // R7
  AST_AGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !hold_older) |=> (older_q == $past(newer_q))); // R6
  AST_NEWER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (newer_q == $past(newest_val))); // R8
endmodule

// File: rtl/ferf_extract.sv
module ferf_extract
  import ferf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mframe_end,
  input  logic xbit_a,
  input  logic xbit_b,
  input  logic oof,
  output logic ferf_status
);
  logic   rst_n_int;
  xpair_t pair;
  logic   decoded;
  logic   newer_q;
  logic   older_q;

  assign pair = '{bit_a: xbit_a, bit_b: xbit_b};

  ferf_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  ferf_xbit_decode u_dec (
    .pair       (pair),
    .prev_state (newer_q),
    .next_state (decoded)
  );

  ferf_history u_hist (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .frame_tick (mframe_end),
    .hold_older (oof),
    .newest_val (decoded),
    .newer_q    (newer_q),
    .older_q    (older_q)
  );

  assign ferf_status = older_q;

  AST_ZEROS_FAIL: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mframe_end && !xbit_a && !xbit_b) |=> newer_q); // R2
  AST_ONES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mframe_end && xbit_a && xbit_b) |=> !newer_q); // R3
  AST_MISMATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mframe_end && (xbit_a != xbit_b)) |=> $stable(newer_q)); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n_int |-> !ferf_status); // R1
endmodule

// File: tb/ferf_extract_test.sv
module ferf_extract_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mframe_end = 1'b0;
  logic xbit_a = 1'b1;
  logic xbit_b = 1'b1;
  logic oof = 1'b0;
  logic ferf_status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ferf_extract uut (
    .clk(clk), .rst_n(rst_n), .mframe_end(mframe_end),
    .xbit_a(xbit_a), .xbit_b(xbit_b), .oof(oof), .ferf_status(ferf_status)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: ferf_status=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic frame(input logic a, input logic b, input logic los);
    @(negedge clk);
    xbit_a = a; xbit_b = b; oof = los; mframe_end = 1'b1;
    @(negedge clk);
    mframe_end = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(2);
    check("R1 during reset", ferf_status, 1'b0);
    rst_n = 1'b1;
    idle(4);
    check("R1 after release", ferf_status, 1'b0);
  endtask

  task automatic t_decode_latency();
    frame(1'b0, 1'b0, 1'b0);
    check("R6 not after first strobe", ferf_status, 1'b0);
    frame(1'b1, 1'b1, 1'b0);
    check("R2 zeros pair reported", ferf_status, 1'b1);
    frame(1'b1, 1'b1, 1'b0);
    check("R3 ones pair reported", ferf_status, 1'b0);
  endtask

  task automatic t_mismatch();
    frame(1'b0, 1'b0, 1'b0);
    frame(1'b0, 1'b1, 1'b0);
    check("R6 failure reported", ferf_status, 1'b1);
    frame(1'b1, 1'b0, 1'b0);
    check("R4 mismatch keeps failure", ferf_status, 1'b1);
    frame(1'b1, 1'b1, 1'b0);
    frame(1'b0, 1'b1, 1'b0);
    check("R3 cleared", ferf_status, 1'b0);
    frame(1'b0, 1'b1, 1'b0);
    check("R4 mismatch keeps clear", ferf_status, 1'b0);
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    xbit_a = 1'b0; xbit_b = 1'b0; oof = 1'b1;
    idle(5);
    oof = 1'b0;
    check("R5 no strobe output stable", ferf_status, 1'b0);
    frame(1'b0, 1'b1, 1'b0);
    check("R5 decoded state untouched", ferf_status, 1'b0);
    frame(1'b0, 1'b1, 1'b0);
    check("R5 decoded state still clear", ferf_status, 1'b0);
  endtask

  task automatic t_oof();
    frame(1'b0, 1'b0, 1'b0);
    frame(1'b0, 1'b0, 1'b0);
    check("R2 settled failure", ferf_status, 1'b1);
    frame(1'b1, 1'b1, 1'b1);
    check("R7 frozen first", ferf_status, 1'b1);
    frame(1'b1, 1'b0, 1'b1);
    check("R7 frozen second", ferf_status, 1'b1);
    frame(1'b1, 1'b1, 1'b1);
    check("R7 frozen third", ferf_status, 1'b1);
    frame(1'b0, 1'b0, 1'b0);
    check("R8 newer updated during oof", ferf_status, 1'b0);
    frame(1'b1, 1'b1, 1'b0);
    check("R9 shifting resumed", ferf_status, 1'b1);
    frame(1'b1, 1'b1, 1'b0);
    check("R9 shifting continues", ferf_status, 1'b0);
  endtask

  initial begin
    t_reset();
    t_decode_latency();
    t_mismatch();
    t_no_strobe();
    t_oof();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule